// File: doc/BRIEF.md
# DMA Page Extension and Active-Channel Tracker

This block sits beside a pair of cascaded DMA controllers and widens their 16-bit transfer offsets into 24-bit memory addresses. Software writes a small file of sixteen byte-wide page registers over a simple I/O port. Address bit 3 splits the file into two banks, one for the byte-wide controller and one for the word-wide controller. Four fixed slots in each bank hold the page values for channels 0 to 3. The other slots are plain scratch bytes.

The block watches the active-low acknowledge lines and records which channel owns the bus. It gives that channel's memory address, gates the memory strobes and steers the controller's end-of-process pulse to that channel alone. A word transfer shifts the offset left by one bit. The high byte of a word read is latched so that a later word write can put it back in place. The cascade acknowledge (channel 4) does not select a channel. Its inverse drives the first controller's hold-acknowledge input.

Top module: `dma_page_tracker`

## Requirements
- R1: Writing `io_wdata` with `io_we` high stores the byte at `io_addr` on the clock edge. `io_rdata` always shows the byte at `io_addr` combinationally.
- R2: `io_addr[3]` selects the bank: 0 is the byte bank and 1 is the word bank. Within a bank, the page for channel 0 is at slot 7, channel 1 at slot 3, channel 2 at slot 1 and channel 3 at slot 2.
- R3: For a byte transfer (`ctl_word`=0), `mem_addr` is the byte-bank page of the active channel (taking channel number modulo 4) in bits 23:16, with `ctl_off` in bits 15:0.
- R4: For a word transfer (`ctl_word`=1), `mem_addr` is the word-bank page of (channel modulo 4) shifted left by 16, plus `ctl_off` shifted left by one. A carry out of bit 16 reaches the page bits.
- R5: A falling edge on `dack_n[c]` (c not 4) makes c the active channel from the next clock. If several fall in one cycle, the highest index wins. A fall overrides the current owner. A high `dack_n` on the active channel with no new fall clears the selection.
- R6: With no active channel, `ctl_rdata` is 0xFF and `mem_rd` and `mem_wr` stay low.
- R7: With a channel active, `ctl_rdata` is `mem_rdata[7:0]`. A word read latches `mem_rdata[15:8]` at the clock. A word write drives `mem_wdata` = {latched byte, `ctl_wdata`}. A byte write drives {0x00, `ctl_wdata`}.
- R8: `eop_out` is zero unless `eop_in` is high and a channel is active. In that case only the bit of the active channel is set, so a change of owner moves the pulse at once.
- R9: `ctl_hlda` is the inverse of `dack_n[4]`. Channel 4 is never reported as active.
- R10: After reset, no channel is active, all page bytes and the latched high byte are zero, and every acknowledge is taken as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_we | input | 1 | Page register write strobe |
| io_addr | input | 4 | Page register index |
| io_wdata | input | 8 | Page register write data |
| io_rdata | output | 8 | Page register read data |
| dack_n | input | 8 | Active-low acknowledges, one per channel |
| ctl_hlda | output | 1 | Hold-acknowledge toward the first controller |
| ctl_off | input | 16 | Transfer offset from the controller |
| ctl_word | input | 1 | 1 = word transfer, 0 = byte transfer |
| ctl_rd | input | 1 | Memory read request |
| ctl_wr | input | 1 | Memory write request |
| ctl_wdata | input | 8 | Byte to write, from the controller |
| ctl_rdata | output | 8 | Byte returned to the controller |
| mem_addr | output | 24 | Full memory address |
| mem_rd | output | 1 | Gated memory read strobe |
| mem_wr | output | 1 | Gated memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| eop_in | input | 1 | End-of-process from the controller |
| eop_out | output | 8 | End-of-process routed per channel |
| act_valid | output | 1 | A channel is active |
| act_chan | output | 3 | Active channel number |

## Verification
Two functions can act in the same cycle: a change of owner while end-of-process is held high, and a change of owner during a transfer. In both, the routed pulse and the address must follow the new owner from exactly the next edge. The bench provokes this by dropping a second acknowledge while the first is still low and `eop_in` is high. It also drops two acknowledges in the same cycle, and it releases the owner in the same cycle that another acknowledge falls. A behavioural model tracks the most recent fall in a plain integer and predicts every output on every clock, including the strobes that must be suppressed after a release.

// File: rtl/dma_page_tracker.sv
module dma_page_tracker #(
  parameter int NCH   = 8,
  parameter int CASC  = 4,
  parameter int PGW   = 8,
  parameter int OFFW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_we,
  input  logic [3:0]        io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [NCH-1:0]    dack_n,
  output logic              ctl_hlda,
  input  logic [OFFW-1:0]   ctl_off,
  input  logic              ctl_word,
  input  logic              ctl_rd,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  output logic [PGW+OFFW-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              eop_in,
  output logic [NCH-1:0]    eop_out,
  output logic              act_valid,
  output logic [$clog2(NCH)-1:0] act_chan
);
  localparam int CW = $clog2(NCH);
  localparam int AW = PGW + OFFW;

  logic [7:0]     pages [16];
  logic [NCH-1:0] dack_q;
  logic [7:0]     hi_q;
  logic [NCH-1:0] fell;
  logic           any_fell;
  logic [CW-1:0]  new_ch;

  function automatic logic [2:0] slot_of(input logic [1:0] ch);
    case (ch)
      2'd0: slot_of = 3'd7;
      2'd1: slot_of = 3'd3;
      2'd2: slot_of = 3'd1;
      default: slot_of = 3'd2;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) pages[i] <= '0;
    end else if (io_we) begin
      pages[io_addr] <= io_wdata;
    end
  end

  assign io_rdata = pages[io_addr];

  always_comb begin
    fell = dack_q & ~dack_n;
    fell[CASC] = 1'b0;
  end

  always_comb begin
    any_fell = 1'b0;
    new_ch   = '0;
    for (int c = 0; c < NCH; c++)
      if (fell[c]) begin
        any_fell = 1'b1;
        new_ch   = CW'(c);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dack_q    <= '1;
      act_valid <= 1'b0;
      act_chan  <= '0;
    end else begin
      dack_q <= dack_n;
      if (any_fell) begin
        act_valid <= 1'b1;
        act_chan  <= new_ch;
      end else if (act_valid && dack_n[act_chan]) begin
        act_valid <= 1'b0;
      end
    end
  end

  logic [1:0]     ch4;
  logic [PGW-1:0] pg_byte, pg_word;
  assign ch4     = act_chan[1:0];
  assign pg_byte = pages[{1'b0, slot_of(ch4)}];
  assign pg_word = pages[{1'b1, slot_of(ch4)}];

  assign mem_addr = ctl_word ? ({pg_word, {OFFW{1'b0}}} + AW'({ctl_off, 1'b0}))
                             : {pg_byte, ctl_off};

  assign mem_rd    = ctl_rd & act_valid;
  assign mem_wr    = ctl_wr & act_valid;
  assign ctl_rdata = act_valid ? mem_rdata[7:0] : 8'hFF;
  assign mem_wdata = ctl_word ? {hi_q, ctl_wdata} : {8'h00, ctl_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else if (ctl_rd && ctl_word && act_valid) hi_q <= mem_rdata[15:8];
  end

  assign eop_out  = (eop_in && act_valid) ? (NCH'(1) << act_chan) : '0;
  assign ctl_hlda = ~dack_n[CASC];

  assert_no_wr_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid |-> (!mem_wr && !mem_rd));
  assert_eop_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eop_out));
  assert_owner_ack_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> ((($past(dack_n) >> act_chan) & NCH'(1)) == '0));
  assert_cascade_not_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> (act_chan != CW'(CASC)));
  assert_hi_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && ctl_word && act_valid) |=> (hi_q == $past(mem_rdata[15:8])));
endmodule

// File: tb/dma_page_tracker_tb.sv
module dma_page_tracker_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic io_we = 0; logic [3:0] io_addr = 0; logic [7:0] io_wdata = 0;
  logic [7:0] io_rdata;
  logic [7:0] dack_n = 8'hFF;
  logic ctl_hlda;
  logic [15:0] ctl_off = 0; logic ctl_word = 0, ctl_rd = 0, ctl_wr = 0;
  logic [7:0] ctl_wdata = 0, ctl_rdata;
  logic [23:0] mem_addr; logic mem_rd, mem_wr;
  logic [15:0] mem_wdata, mem_rdata = 0;
  logic eop_in = 0; logic [7:0] eop_out;
  logic act_valid; logic [2:0] act_chan;

  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_page_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .dack_n(dack_n), .ctl_hlda(ctl_hlda), .ctl_off(ctl_off),
    .ctl_word(ctl_word), .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .eop_in(eop_in), .eop_out(eop_out),
    .act_valid(act_valid), .act_chan(act_chan));

  // reference model
  int m_pages [16];
  int m_active = -1;
  int m_hi = 0;
  logic [7:0] m_prev = 8'hFF;

  function automatic int slot(int ch);
    case (ch % 4)
      0: return 7;
      1: return 3;
      2: return 1;
      default: return 2;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_pages[i] = 0;
      m_active = -1; m_hi = 0; m_prev = 8'hFF;
    end else begin
      int newest;
      if (ctl_rd && ctl_word && m_active >= 0) m_hi = mem_rdata[15:8];
      if (io_we) m_pages[io_addr] = io_wdata;
      newest = -1;
      for (int c = 0; c < 8; c++)
        if (c != 4 && m_prev[c] && !dack_n[c]) newest = c;
      if (newest >= 0) m_active = newest;
      else if (m_active >= 0 && dack_n[m_active]) m_active = -1;
      m_prev = dack_n;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    longint ea, ewd, erd, eeop;
    chk("R1", "io_rdata", io_rdata, m_pages[io_addr]);
    chk("R5", "act_valid", act_valid, m_active >= 0);
    if (m_active >= 0) chk("R5", "act_chan", act_chan, m_active);
    chk("R9", "ctl_hlda", ctl_hlda, !dack_n[4]);
    chk("R6", "mem_rd", mem_rd, ctl_rd && m_active >= 0);
    chk("R6", "mem_wr", mem_wr, ctl_wr && m_active >= 0);
    erd = (m_active >= 0) ? mem_rdata[7:0] : 8'hFF;
    chk("R7", "ctl_rdata", ctl_rdata, erd);
    if (m_active >= 0) begin
      if (ctl_word) ea = ((longint'(m_pages[8 + slot(m_active)]) << 16) + (longint'(ctl_off) * 2)) & 24'hFFFFFF;
      else          ea = (longint'(m_pages[slot(m_active)]) << 16) | ctl_off;
      chk(ctl_word ? "R4" : "R3", "mem_addr", mem_addr, ea);
      ewd = ctl_word ? ((m_hi << 8) | ctl_wdata) : ctl_wdata;
      chk("R7", "mem_wdata", mem_wdata, ewd);
    end
    eeop = (eop_in && m_active >= 0) ? (64'd1 << m_active) : 0;
    chk("R8", "eop_out", eop_out, eeop);
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); compare();
  endtask

  task automatic wr_page(input int a, input int d);
    io_we = 1; io_addr = 4'(a); io_wdata = 8'(d); tick(); io_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R10", "reset act_valid", act_valid, 0);
    for (int a = 0; a < 16; a++) begin io_addr = 4'(a); #1; chk("R10", "reset page", io_rdata, 0); end
    // R1 R2 fill every byte with distinct values
    for (int a = 0; a < 16; a++) wr_page(a, 8'h10 + a * 7);
    for (int a = 0; a < 16; a++) begin io_addr = 4'(a); tick(); end
    // R6 idle read / write suppressed
    ctl_rd = 1; ctl_wr = 1; mem_rdata = 16'hABCD; tick();
    chk("R6", "idle rdata FF", ctl_rdata, 8'hFF);
    ctl_rd = 0; ctl_wr = 0;
    // R3 byte transfers on channels 0..3
    for (int c = 0; c < 4; c++) begin
      dack_n = 8'hFF; dack_n[c] = 0; ctl_word = 0; ctl_off = 16'hFFFF - 16'(c); tick(); tick();
      chk("R3", "byte owner", act_chan, c);
      dack_n = 8'hFF; tick();
    end
    // R4 R7 word read then write on channels 5..7 with carry
    for (int c = 5; c < 8; c++) begin
      dack_n = 8'hFF; dack_n[c] = 0; tick();
      ctl_word = 1; ctl_off = 16'hFFFF; ctl_rd = 1; mem_rdata = 16'h5A00 + 16'(c); tick();
      ctl_rd = 0; ctl_wr = 1; ctl_wdata = 8'h3C; tick();
      chk("R7", "word write", mem_wdata, {8'h5A, 8'h3C});
      ctl_wr = 0; dack_n = 8'hFF; tick();
    end
    // R9 cascade does not select
    dack_n = 8'hEF; tick(); tick();
    chk("R9", "cascade no owner", act_valid, 0);
    chk("R9", "hlda", ctl_hlda, 1);
    dack_n = 8'hFF; tick();
    // R5 simultaneous falls: highest wins
    dack_n = 8'b1011_1011; tick(); tick();
    chk("R5", "tie highest", act_chan, 6);
    dack_n = 8'hFF; tick();
    // R8 owner change while eop held
    eop_in = 1; dack_n = 8'b1111_1101; tick(); tick();
    chk("R8", "eop ch1", eop_out, 8'h02);
    dack_n = 8'b0111_1101; tick(); tick();
    chk("R8", "eop moves ch7", eop_out, 8'h80);
    // release of previous owner (ch1) while ch7 owns: no effect
    dack_n = 8'b0111_1111; tick();
    // release and new fall in the same cycle
    dack_n = 8'b1111_0111; tick(); tick();
    chk("R5", "fall beats release", act_chan, 3);
    dack_n = 8'hFF; tick(); tick();
    chk("R5", "released", act_valid, 0);
    eop_in = 0;
    // random phase
    for (int n = 0; n < 3000; n++) begin
      io_we = ($urandom % 8) == 0; io_addr = 4'($urandom); io_wdata = 8'($urandom);
      if (($urandom % 4) == 0) dack_n = 8'($urandom) | 8'h5A;
      ctl_off = 16'($urandom); ctl_word = 1'($urandom); ctl_rd = 1'($urandom);
      ctl_wr = 1'($urandom); ctl_wdata = 8'($urandom); mem_rdata = 16'($urandom);
      eop_in = 1'($urandom);
      tick();
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule